// File: doc/BRIEF.md
# Fault Isolation Register with Per-Bit Response Routing

This block collects error pulses from the logic around it into a vector of sticky fault bits. Each fault position has its own classification: one bit in each of two action registers forms a two-bit response code, and one mask bit can silence the position completely. Every unmasked fault that is set is steered by its code to one of four registered response outputs. The four responses are system checkstop, recoverable error, attention and local checkstop. Each output is the OR of all positions routed to it.

Software uses a small word-wide register port to read and write the fault, action and mask vectors. The fault and mask vectors also have set-only and clear-only aliases. A single position can therefore be raised, lowered or reclassified without rewriting its neighbours. A read-modify-write through the plain addresses does the same job for the action vectors. At reset every position is masked, so nothing is reported until software opts a bit in.

Top module: `fault_isolation_reg`

## Requirements
- R1: A pulse on bit n of `errIn` sets fault bit n at the next clock edge. The bit stays set until software clears it through address 2 (write 1 to clear) or overwrites it through address 0.
- R2: When an error pulse and a clear of the same bit arrive in the same cycle, the bit ends up set.
- R3: When mask bit n is 1, fault bit n drives none of the four response outputs, whatever its action bits hold.
- R4: An unmasked, set fault bit whose action0 bit is 0 and action1 bit is 0 asserts `sysCheckstop`.
- R5: An unmasked, set fault bit whose action0 bit is 0 and action1 bit is 1 asserts `recovErr`.
- R6: An unmasked, set fault bit whose action0 bit is 1 and action1 bit is 0 asserts `attnOut`.
- R7: An unmasked, set fault bit whose action0 bit is 1 and action1 bit is 1 asserts `localCheckstop`.
- R8: Each response output is registered. It reflects the fault, mask and action state one clock edge later, which is two edges after the `errIn` pulse.
- R9: During and after reset the fault vector is 0, the mask vector is all ones, both action vectors are 0, and all responses are 0.
- R10: The register addresses are as follows:
  - 0 is fault read/write, 1 is fault set-only, 2 is fault clear-only.
  - 3 is action0 and 4 is action1.
  - 5 is mask read/write, 6 is mask set-only, 7 is mask clear-only.
  - `regRdata` shows the addressed register combinationally; an alias reads as its base register.
  - A read-modify-write of one bit leaves every other position unchanged.
- R11: A write to a set-only or clear-only alias changes only the positions where `regWdata` is 1.
- R12: Clearing a mask bit while its fault bit is already set asserts the selected response one edge after the mask write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| errIn | input | WIDTH | Error pulses, one per fault position |
| regWe | input | 1 | Register write enable |
| regAddr | input | 3 | Register address |
| regWdata | input | WIDTH | Write data |
| regRdata | output | WIDTH | Read data of the addressed register |
| sysCheckstop | output | 1 | System checkstop response |
| recovErr | output | 1 | Recoverable error response |
| attnOut | output | 1 | Attention response |
| localCheckstop | output | 1 | Local checkstop response |

## Verification
Register contents change at the first edge after a write or error pulse, and a read shows the new value in the low phase that follows. The response outputs trail the register state by one more edge. An error pulse therefore becomes visible on a response two edges later, and a mask or action write one edge later. The directed checks sample each response once before and once after the due edge, to pin this latency down exactly. A behavioural model advances on each rising edge in the same order and is compared 2 ns after every edge, away from the edge.

// File: rtl/firr_pkg.sv
package firr_pkg;

  localparam int ADDR_W   = 3;
  localparam int NUM_RESP = 4;

  // Response index equals the {action0, action1} code of a position.
  localparam int RESP_SYS   = 0;
  localparam int RESP_RECOV = 1;
  localparam int RESP_ATTN  = 2;
  localparam int RESP_LOCAL = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_FAULT     = 3'd0,
    ADDR_FAULT_SET = 3'd1,
    ADDR_FAULT_CLR = 3'd2,
    ADDR_ACT0      = 3'd3,
    ADDR_ACT1      = 3'd4,
    ADDR_MASK      = 3'd5,
    ADDR_MASK_SET  = 3'd6,
    ADDR_MASK_CLR  = 3'd7
  } regAddr_e;

  typedef enum logic [1:0] {
    RD_FAULT = 2'd0,
    RD_ACT0  = 2'd1,
    RD_ACT1  = 2'd2,
    RD_MASK  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic faultWr;
    logic faultSet;
    logic faultClr;
    logic act0Wr;
    logic act1Wr;
    logic maskWr;
    logic maskSet;
    logic maskClr;
  } wrStrobe_t;

endpackage

// File: rtl/firr_ctrl.sv
module firr_ctrl
  import firr_pkg::*;
(
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  output wrStrobe_t         strobe,
  output rdSel_e            rdSel
);

  always_comb begin
    strobe = '0;
    rdSel  = RD_FAULT;
    unique case (regAddr_e'(regAddr))
      ADDR_FAULT:     begin strobe.faultWr  = regWe; rdSel = RD_FAULT; end
      ADDR_FAULT_SET: begin strobe.faultSet = regWe; rdSel = RD_FAULT; end
      ADDR_FAULT_CLR: begin strobe.faultClr = regWe; rdSel = RD_FAULT; end
      ADDR_ACT0:      begin strobe.act0Wr   = regWe; rdSel = RD_ACT0;  end
      ADDR_ACT1:      begin strobe.act1Wr   = regWe; rdSel = RD_ACT1;  end
      ADDR_MASK:      begin strobe.maskWr   = regWe; rdSel = RD_MASK;  end
      ADDR_MASK_SET:  begin strobe.maskSet  = regWe; rdSel = RD_MASK;  end
      ADDR_MASK_CLR:  begin strobe.maskClr  = regWe; rdSel = RD_MASK;  end
      default:        begin strobe = '0;             rdSel = RD_FAULT; end
    endcase
  end

endmodule

// File: rtl/firr_route.sv
module firr_route
  import firr_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0]    faultVec,
  input  logic [WIDTH-1:0]    maskVec,
  input  logic [WIDTH-1:0]    act0Vec,
  input  logic [WIDTH-1:0]    act1Vec,
  output logic [NUM_RESP-1:0] respNext
);

  logic [WIDTH-1:0] liveVec;
  assign liveVec = faultVec & ~maskVec;

  for (genvar k = 0; k < NUM_RESP; k++) begin : g_resp
    localparam logic [1:0] CODE = 2'(k);
    logic [WIDTH-1:0] hitA0;
    logic [WIDTH-1:0] hitA1;
    if (CODE[1]) begin : g_a0_one
      assign hitA0 = act0Vec;
    end else begin : g_a0_zero
      assign hitA0 = ~act0Vec;
    end
    if (CODE[0]) begin : g_a1_one
      assign hitA1 = act1Vec;
    end else begin : g_a1_zero
      assign hitA1 = ~act1Vec;
    end
    assign respNext[k] = |(liveVec & hitA0 & hitA1);
  end

endmodule

// File: rtl/firr_datapath.sv
module firr_datapath
  import firr_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WIDTH-1:0]    errIn,
  input  logic [WIDTH-1:0]    wdata,
  input  wrStrobe_t           strobe,
  input  rdSel_e              rdSel,
  output logic [WIDTH-1:0]    rdata,
  output logic [WIDTH-1:0]    faultQ,
  output logic [WIDTH-1:0]    maskQ,
  output logic [WIDTH-1:0]    act0Q,
  output logic [WIDTH-1:0]    act1Q,
  output logic [NUM_RESP-1:0] respQ
);

  logic [WIDTH-1:0]    faultBase;
  logic [WIDTH-1:0]    faultNext;
  logic [WIDTH-1:0]    maskNext;
  logic [WIDTH-1:0]    act0Next;
  logic [WIDTH-1:0]    act1Next;
  logic [NUM_RESP-1:0] respNext;

  always_comb begin
    faultBase = faultQ;
    if (strobe.faultWr)  faultBase = wdata;
    if (strobe.faultSet) faultBase = faultQ | wdata;
    if (strobe.faultClr) faultBase = faultQ & ~wdata;
    faultNext = faultBase | errIn;   // an incoming error beats any clear
  end

  always_comb begin
    maskNext = maskQ;
    if (strobe.maskWr)  maskNext = wdata;
    if (strobe.maskSet) maskNext = maskQ | wdata;
    if (strobe.maskClr) maskNext = maskQ & ~wdata;
  end

  assign act0Next = strobe.act0Wr ? wdata : act0Q;
  assign act1Next = strobe.act1Wr ? wdata : act1Q;

  firr_route #(.WIDTH(WIDTH)) u_route (
    .faultVec (faultQ),
    .maskVec  (maskQ),
    .act0Vec  (act0Q),
    .act1Vec  (act1Q),
    .respNext (respNext)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      faultQ <= '0;
      maskQ  <= '1;
      act0Q  <= '0;
      act1Q  <= '0;
      respQ  <= '0;
    end else begin
      faultQ <= faultNext;
      maskQ  <= maskNext;
      act0Q  <= act0Next;
      act1Q  <= act1Next;
      respQ  <= respNext;
    end
  end

  always_comb begin
    unique case (rdSel)
      RD_FAULT: rdata = faultQ;
      RD_ACT0:  rdata = act0Q;
      RD_ACT1:  rdata = act1Q;
      RD_MASK:  rdata = maskQ;
      default:  rdata = faultQ;
    endcase
  end

endmodule

// File: rtl/fault_isolation_reg.sv
module fault_isolation_reg
  import firr_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIDTH-1:0]  errIn,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [WIDTH-1:0]  regWdata,
  output logic [WIDTH-1:0]  regRdata,
  output logic              sysCheckstop,
  output logic              recovErr,
  output logic              attnOut,
  output logic              localCheckstop
);

  wrStrobe_t           strobe;
  rdSel_e              rdSel;
  logic [WIDTH-1:0]    faultVec;
  logic [WIDTH-1:0]    maskVec;
  logic [WIDTH-1:0]    act0Vec;
  logic [WIDTH-1:0]    act1Vec;
  logic [NUM_RESP-1:0] respVec;

  firr_ctrl u_ctrl (
    .regWe   (regWe),
    .regAddr (regAddr),
    .strobe  (strobe),
    .rdSel   (rdSel)
  );

  firr_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .errIn  (errIn),
    .wdata  (regWdata),
    .strobe (strobe),
    .rdSel  (rdSel),
    .rdata  (regRdata),
    .faultQ (faultVec),
    .maskQ  (maskVec),
    .act0Q  (act0Vec),
    .act1Q  (act1Vec),
    .respQ  (respVec)
  );

  assign sysCheckstop   = respVec[RESP_SYS];
  assign recovErr       = respVec[RESP_RECOV];
  assign attnOut        = respVec[RESP_ATTN];
  assign localCheckstop = respVec[RESP_LOCAL];

endmodule

// File: rtl/firr_checker.sv
module firr_checker #(
  parameter int WIDTH = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] errIn,
  input logic             regWe,
  input logic [2:0]       regAddr,
  input logic [WIDTH-1:0] regWdata,
  input logic [WIDTH-1:0] faultVec,
  input logic [WIDTH-1:0] maskVec,
  input logic             sysCheckstop,
  input logic             recovErr,
  input logic             attnOut,
  input logic             localCheckstop
);

  logic anyResp;
  assign anyResp = sysCheckstop | recovErr | attnOut | localCheckstop;

  // R1: set bits survive any cycle without a fault overwrite or clear
  p_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(regWe && (regAddr == 3'd0 || regAddr == 3'd2))
      |=> ((faultVec & $past(faultVec)) == $past(faultVec)));

  // R2: an error pulse always lands, even against a clear of the same bit
  p_err_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|errIn) |=> ((faultVec & $past(errIn)) == $past(errIn)));

  // R3: a fully masked vector yields no response on the next edge
  p_mask_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (&maskVec) |=> !anyResp);

  // R8: a response implies an unmasked set fault one edge earlier
  p_resp_needs_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    anyResp |-> $past(|(faultVec & ~maskVec)));

  // R11: clear-only alias removes the written bits unless re-raised
  p_fault_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (regWe && regAddr == 3'd2)
      |=> ((faultVec & $past(regWdata) & ~$past(errIn)) == '0));

  // R11: set-only mask alias raises the written bits
  p_mask_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (regWe && regAddr == 3'd6)
      |=> ((maskVec & $past(regWdata)) == $past(regWdata)));

endmodule

bind fault_isolation_reg firr_checker #(.WIDTH(WIDTH)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .errIn          (errIn),
  .regWe          (regWe),
  .regAddr        (regAddr),
  .regWdata       (regWdata),
  .faultVec       (faultVec),
  .maskVec        (maskVec),
  .sysCheckstop   (sysCheckstop),
  .recovErr       (recovErr),
  .attnOut        (attnOut),
  .localCheckstop (localCheckstop)
);

// File: tb/fault_isolation_reg_tb.sv
`timescale 1ns/1ps
module fault_isolation_reg_tb;

  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] errIn = '0;
  logic         regWe = 1'b0;
  logic [2:0]   regAddr = 3'd0;
  logic [W-1:0] regWdata = '0;
  logic [W-1:0] regRdata;
  logic         sysCheckstop, recovErr, attnOut, localCheckstop;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  fault_isolation_reg #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .errIn(errIn), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .sysCheckstop(sysCheckstop), .recovErr(recovErr),
    .attnOut(attnOut), .localCheckstop(localCheckstop)
  );

  // ---------------- behavioural reference model ----------------
  logic [W-1:0] mFault, mMask, mA0, mA1;
  logic [3:0]   mResp;   // {local, attn, recov, sys}

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mFault = '0; mMask = '1; mA0 = '0; mA1 = '0; mResp = '0;
    end else begin
      logic [3:0] r;
      r = '0;
      for (int i = 0; i < W; i++) begin
        if (mFault[i] && !mMask[i]) begin
          case ({mA0[i], mA1[i]})
            2'b00: r[0] = 1'b1;
            2'b01: r[1] = 1'b1;
            2'b10: r[2] = 1'b1;
            default: r[3] = 1'b1;
          endcase
        end
      end
      if (regWe) begin
        case (regAddr)
          3'd0: mFault = regWdata;
          3'd1: mFault = mFault | regWdata;
          3'd2: mFault = mFault & ~regWdata;
          3'd3: mA0 = regWdata;
          3'd4: mA1 = regWdata;
          3'd5: mMask = regWdata;
          3'd6: mMask = mMask | regWdata;
          default: mMask = mMask & ~regWdata;
        endcase
      end
      mFault = mFault | errIn;
      mResp = r;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // lockstep comparison 2 ns after each rising edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !finished) begin
      logic [W-1:0] expRd;
      case (regAddr)
        3'd0, 3'd1, 3'd2: expRd = mFault;
        3'd3: expRd = mA0;
        3'd4: expRd = mA1;
        default: expRd = mMask;
      endcase
      check({localCheckstop, attnOut, recovErr, sysCheckstop} == mResp,
            "R4 R5 R6 R7 model responses",
            W'({localCheckstop, attnOut, recovErr, sysCheckstop}), W'(mResp));
      check(regRdata === expRd, "R10 model readback", regRdata, expRd);
    end
  end

  // ---------------- stimulus helpers (called at a falling edge) ----------------
  task automatic doWrite(input logic [2:0] a, input logic [W-1:0] d,
                         input logic [W-1:0] e = '0);
    regWe = 1'b1; regAddr = a; regWdata = d; errIn = e;
    @(negedge clk);
    regWe = 1'b0; errIn = '0;
  endtask

  task automatic pulse(input logic [W-1:0] e);
    errIn = e;
    @(negedge clk);
    errIn = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] v);
    regAddr = a;
    #1;
    v = regRdata;
  endtask

  task automatic checkResp(input logic [3:0] exp, input string tag);
    check({localCheckstop, attnOut, recovErr, sysCheckstop} == exp, tag,
          W'({localCheckstop, attnOut, recovErr, sysCheckstop}), W'(exp));
  endtask

  function automatic logic [W-1:0] b(input int n);
    return W'(1) << n;
  endfunction

  initial begin
    #400000;
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    repeat (3) @(negedge clk);
    checkResp(4'b0000, "R9 responses low in reset");
    rst_n = 1'b1;
    rd(3'd5, v); check(v == '1, "R9 mask all ones", v, '1);
    rd(3'd0, v); check(v == '0, "R9 fault zero", v, '0);
    rd(3'd3, v); check(v == '0, "R9 action0 zero", v, '0);
    rd(3'd4, v); check(v == '0, "R9 action1 zero", v, '0);

    // masked fault: stored, but silent
    pulse(b(5));
    rd(3'd0, v); check(v == b(5), "R1 error pulse sets bit", v, b(5));
    @(negedge clk);
    checkResp(4'b0000, "R3 masked fault silent");

    // unmask an already set fault
    doWrite(3'd7, b(5));
    checkResp(4'b0000, "R12 not yet on mask-write edge");
    @(negedge clk);
    checkResp(4'b0001, "R12 R4 system checkstop after unmask");
    rd(3'd6, v); check(v == ~b(5), "R10 R11 mask alias reads mask", v, ~b(5));

    // recoverable on bit 9
    doWrite(3'd4, b(9));
    doWrite(3'd7, b(9));
    pulse(b(9));
    checkResp(4'b0001, "R8 response not yet on fault edge");
    @(negedge clk);
    checkResp(4'b0011, "R5 R8 recoverable two edges after pulse");

    // attention on bit 20
    doWrite(3'd3, b(20));
    doWrite(3'd7, b(20));
    pulse(b(20));
    @(negedge clk);
    checkResp(4'b0111, "R6 attention");

    // local checkstop on bit 40 by read-modify-write
    rd(3'd3, v); doWrite(3'd3, v | b(40));
    rd(3'd4, v); doWrite(3'd4, v | b(40));
    rd(3'd3, v); check(v == (b(20) | b(40)), "R10 RMW action0 keeps neighbours", v, b(20) | b(40));
    rd(3'd4, v); check(v == (b(9) | b(40)), "R10 RMW action1 keeps neighbours", v, b(9) | b(40));
    doWrite(3'd7, b(40));
    pulse(b(40));
    @(negedge clk);
    checkResp(4'b1111, "R7 local checkstop");

    // clear-only alias on bit 5
    doWrite(3'd2, b(5));
    rd(3'd0, v); check(v == (b(9) | b(20) | b(40)), "R11 fault clear touches one bit", v, b(9) | b(20) | b(40));
    @(negedge clk);
    checkResp(4'b1110, "R1 others stay sticky after clear");

    // simultaneous error and clear
    doWrite(3'd2, b(9), b(9));
    rd(3'd0, v); check(v[9] == 1'b1, "R2 set wins over clear", W'(v[9]), W'(1));

    // set-only mask alias on bit 40
    doWrite(3'd6, b(40));
    rd(3'd5, v); check(v == ~(b(5) | b(9) | b(20)), "R11 mask set touches one bit", v, ~(b(5) | b(9) | b(20)));
    @(negedge clk);
    checkResp(4'b0110, "R3 remasked bit silent");

    // direct overwrite and set-only alias of the fault vector
    doWrite(3'd0, '0);
    rd(3'd0, v); check(v == '0, "R10 fault overwrite", v, '0);
    @(negedge clk);
    checkResp(4'b0000, "R1 cleared faults drop responses");
    doWrite(3'd1, b(20));
    rd(3'd1, v); check(v == b(20), "R11 fault set alias", v, b(20));
    @(negedge clk);
    checkResp(4'b0100, "R6 attention via set alias");

    // random traffic against the model
    for (int i = 0; i < 400; i++) begin
      regWe = 1'($urandom);
      regAddr = 3'($urandom);
      regWdata = {$urandom, $urandom};
      errIn = ($urandom % 4 == 0) ? ({$urandom, $urandom} & {$urandom, $urandom}) : '0;
      @(negedge clk);
    end
    regWe = 1'b0; errIn = '0;
    @(negedge clk);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule